// File: doc/BRIEF.md
# Cascaded Signed Dot-Product Pipeline

This block computes the dot product of N pairs of signed integers. It accepts one full vector every clock cycle and returns one result per cycle. It does not reduce the products through a balanced tree. Instead it strings N multiply-accumulate stages into a chain. Each stage multiplies its own pair, adds the product to the running total handed on by the stage before it, and registers the result for the next stage.

Pair k reaches its stage k cycles after it is presented. To make this work, each pair passes through a skew line of k registers, so that it meets the running total in the right cycle. A valid flag runs alongside the data through a matching delay. A parameter can add one more register after the last stage, which gives a clean timing boundary at the output.

Top module: `dot_chain`

## Requirements
- R1: While `out_valid` is high, `sum` read as a two's-complement value of ACC_W = 2*W + ceil(log2 N) bits equals the sum of x_k*y_k over k = 0..N-1. Pair k is taken from bits [k*W +: W] of `x_flat` and `y_flat`, and each of those fields is a signed two's-complement value.
- R2: With OUT_REG = 0, the result of a vector presented before rising edge p appears on the outputs right after edge p+N-1, which is a latency of N edges.
- R3: With OUT_REG = 1, the same result appears one edge later, after edge p+N, which is a latency of N+1 edges.
- R4: `out_valid` repeats `in_valid` delayed by exactly the latency of R2 or R3. A cycle with `in_valid` low produces a cycle with `out_valid` low, whatever values are on the data inputs.
- R5: While `rst` is high (synchronous, active high), `out_valid` and `sum` are zero after the next rising edge. In the first cycle after `rst` falls, `out_valid` is still low.
- R6: Vectors presented on consecutive cycles give independent, correct results on consecutive cycles. No result mixes the pairs of different vectors.
- R7: The accumulator never overflows. When every x and every y is -2^(W-1), `sum` equals N*2^(2W-2). When every x is -2^(W-1) and every y is 2^(W-1)-1, `sum` equals the exact negative total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the current input vector as valid |
| x_flat | input | N*W | Packed signed x operands; pair k is at [k*W +: W] |
| y_flat | input | N*W | Packed signed y operands; pair k is at [k*W +: W] |
| out_valid | output | 1 | Marks `sum` as holding a result |
| sum | output | ACC_W | Signed dot product, ACC_W = 2*W + ceil(log2 N) |

## Verification
The bench sweeps every operand value on each pair position while the other pairs carry a moving background pattern. A design that sliced the packed inputs in the wrong place, or that skewed one pair by the wrong number of cycles, would add a neighbouring vector's product and give wrong sums only on that position. Idle cycles with garbage data are interleaved into the stream, so a valid delay of the wrong length or data that leaks into an idle slot shows up as a misplaced or spurious `out_valid`. Vectors with every operand at its extreme catch truncated or zero-extended accumulation, which would wrap the large positive total or lose the sign of the negative one.

// File: rtl/dot_chain_pkg.sv
package dot_chain_pkg;

   // Width of the running total: full product width plus growth for N terms.
   function automatic int acc_width(input int n, input int w);
      return 2 * w + $clog2(n);
   endfunction

   // Width of one packed operand bus.
   function automatic int bus_width(input int n, input int w);
      return n * w;
   endfunction

endpackage

// File: rtl/dot_chain_dly.sv
// Fixed-length register chain used for operand skew and valid alignment.
module dot_chain_dly #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("dot_chain_dly: DEPTH must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("dot_chain_dly: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] tap [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) tap[0] <= '0;
      else     tap[0] <= d;
   end

   for (genvar s = 1; s < DEPTH; s++) begin : g_tap
      always_ff @(posedge clk) begin
         if (rst) tap[s] <= '0;
         else     tap[s] <= tap[s-1];
      end
   end

   assign q = tap[DEPTH-1];

endmodule

// File: rtl/dot_chain_stage.sv
// One link of the cascade: registered (carry_in + a*b).
module dot_chain_stage #(
   parameter int W     = 8,
   parameter int ACC_W = 18
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [W-1:0]     a,
   input  logic signed [W-1:0]     b,
   input  logic signed [ACC_W-1:0] carry_in,
   output logic signed [ACC_W-1:0] carry_out
);

   localparam int PROD_W = 2 * W;

   if (ACC_W < PROD_W) begin : g_bad_acc
      $error("dot_chain_stage: ACC_W narrower than product");
   end

   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  prod_ext;
   logic signed [ACC_W-1:0]  total;

   always_comb begin
      prod     = a * b;
      prod_ext = ACC_W'(prod);
      total    = carry_in + prod_ext;
   end

   always_ff @(posedge clk) begin
      if (rst) carry_out <= '0;
      else     carry_out <= total;
   end

endmodule

// File: rtl/dot_chain.sv
// Cascaded signed dot product, one vector per cycle.
module dot_chain #(
   parameter int  N       = 4,
   parameter int  W       = 8,
   parameter bit  OUT_REG = 1'b0,
   localparam int ACC_W   = dot_chain_pkg::acc_width(N, W),
   localparam int BUS_W   = dot_chain_pkg::bus_width(N, W)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [BUS_W-1:0] x_flat,
   input  logic [BUS_W-1:0] y_flat,
   output logic             out_valid,
   output logic [ACC_W-1:0] sum
);

   localparam int LAT = N + (OUT_REG ? 1 : 0);

   if (N < 1) begin : g_bad_n
      $error("dot_chain: N must be at least 1");
   end
   if (W < 2) begin : g_bad_w
      $error("dot_chain: W must be at least 2");
   end

   logic signed [ACC_W-1:0] part_sum [N];

   for (genvar k = 0; k < N; k++) begin : g_lane
      logic [2*W-1:0] pair_now;
      logic [2*W-1:0] pair_skew;
      logic signed [ACC_W-1:0] carry;

      assign pair_now = {x_flat[k*W +: W], y_flat[k*W +: W]};

      if (k == 0) begin : g_head
         assign pair_skew = pair_now;
         assign carry     = '0;
      end else begin : g_tail
         dot_chain_dly #(
            .WIDTH (2 * W),
            .DEPTH (k)
         ) u_skew (
            .clk (clk),
            .rst (rst),
            .d   (pair_now),
            .q   (pair_skew)
         );
         assign carry = part_sum[k-1];
      end

      dot_chain_stage #(
         .W     (W),
         .ACC_W (ACC_W)
      ) u_stage (
         .clk       (clk),
         .rst       (rst),
         .a         (pair_skew[2*W-1:W]),
         .b         (pair_skew[W-1:0]),
         .carry_in  (carry),
         .carry_out (part_sum[k])
      );
   end

   dot_chain_dly #(
      .WIDTH (1),
      .DEPTH (LAT)
   ) u_vld (
      .clk (clk),
      .rst (rst),
      .d   (in_valid),
      .q   (out_valid)
   );

   if (OUT_REG) begin : g_oreg
      logic [ACC_W-1:0] sum_q;
      always_ff @(posedge clk) begin
         if (rst) sum_q <= '0;
         else     sum_q <= part_sum[N-1];
      end
      assign sum = sum_q;
   end else begin : g_ocomb
      assign sum = part_sum[N-1];
   end

endmodule

// File: rtl/dot_chain_chk.sv
// Property checker attached to every dot_chain instance.
module dot_chain_chk #(
   parameter int  N       = 4,
   parameter int  W       = 8,
   parameter bit  OUT_REG = 1'b0,
   localparam int ACC_W   = dot_chain_pkg::acc_width(N, W)
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    in_valid,
   input logic signed [W-1:0]     x0,
   input logic signed [W-1:0]     y0,
   input logic                    out_valid,
   input logic signed [ACC_W-1:0] sum,
   input logic signed [ACC_W-1:0] first_sum,
   input logic signed [ACC_W-1:0] last_sum
);

   localparam int LAT = N + (OUT_REG ? 1 : 0);

   logic [15:0] pending;
   always_ff @(posedge clk) begin
      if (rst) pending <= '0;
      else     pending <= pending + 16'(in_valid) - 16'(out_valid);
   end

   logic signed [2*W-1:0] head_prod;
   assign head_prod = x0 * y0;

   // R1
   stage0_prod_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> first_sum == ACC_W'($past(head_prod)));

   // R4
   no_orphan_valid_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> pending != 16'd0);

   // R4
   inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
      pending <= 16'(LAT));

   // R5
   reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid);

   if (OUT_REG) begin : g_oreg_chk
      // R3
      out_stage_chk: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |-> sum == $past(last_sum));
   end

endmodule

bind dot_chain dot_chain_chk #(
   .N       (N),
   .W       (W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .x0        (x_flat[W-1:0]),
   .y0        (y_flat[W-1:0]),
   .out_valid (out_valid),
   .sum       (sum),
   .first_sum (part_sum[0]),
   .last_sum  (part_sum[N-1])
);

// File: tb/dot_chain_bench.sv
`timescale 1ns/1ps
module dot_chain_bench;

   localparam int N     = 4;
   localparam int W     = 3;
   localparam int ACC_W = 2 * W + 2;
   localparam int VMIN  = -(1 << (W-1));
   localparam int VMAX  = (1 << (W-1)) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [N*W-1:0] x_flat = '0;
   logic [N*W-1:0] y_flat = '0;
   logic           vld_a, vld_b;
   logic [ACC_W-1:0] sum_a, sum_b;

   always #10 clk = ~clk;

   dot_chain #(.N(N), .W(W), .OUT_REG(1'b0)) u_dot_chain (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .x_flat(x_flat), .y_flat(y_flat),
      .out_valid(vld_a), .sum(sum_a));

   dot_chain #(.N(N), .W(W), .OUT_REG(1'b1)) u_dot_chain_reg (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .x_flat(x_flat), .y_flat(y_flat),
      .out_valid(vld_b), .sum(sum_b));

   int n_tests = 0;
   int n_fail  = 0;
   int ecnt    = 0;
   bit done    = 1'b0;
   int exp_sum [0:4095];
   bit exp_vld [0:4095];

   always @(posedge clk) ecnt <= ecnt + 1;

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Compare both instances against the vector captured LAT-1 edges before.
   task automatic check_outputs();
      int ia = ecnt - N + 1;
      int ib = ecnt - N;
      if (ia >= 1) begin
         check("R2/R4 valid (no out reg)", int'(vld_a), int'(exp_vld[ia]));
         if (exp_vld[ia])
            check("R1/R2/R6 sum (no out reg)", int'($signed(sum_a)), exp_sum[ia]);
      end
      if (ib >= 1) begin
         check("R3/R4 valid (out reg)", int'(vld_b), int'(exp_vld[ib]));
         if (exp_vld[ib])
            check("R1/R3/R6 sum (out reg)", int'($signed(sum_b)), exp_sum[ib]);
      end
   endtask

   task automatic drive(input bit v, input int xs [N], input int ys [N]);
      int acc = 0;
      for (int k = 0; k < N; k++) begin
         x_flat[k*W +: W] = W'(xs[k]);
         y_flat[k*W +: W] = W'(ys[k]);
         acc += xs[k] * ys[k];
      end
      in_valid = v;
      exp_vld[ecnt+1] = v;
      exp_sum[ecnt+1] = acc;
   endtask

   task automatic step(input bit v, input int xs [N], input int ys [N]);
      @(negedge clk);
      check_outputs();
      drive(v, xs, ys);
   endtask

   initial begin
      int xs [N];
      int ys [N];
      int bg = 0;
      for (int i = 0; i < 4096; i++) begin
         exp_sum[i] = 0;
         exp_vld[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      // R5: outputs cleared while in reset
      check("R5 valid in reset", int'(vld_a), 0);
      check("R5 sum in reset", int'(sum_a), 0);
      check("R5 valid in reset (out reg)", int'(vld_b), 0);
      check("R5 sum in reset (out reg)", int'(sum_b), 0);
      rst = 1'b0;

      // R1 R6: every value on every lane, background pattern elsewhere
      for (int lane = 0; lane < N; lane++) begin
         for (int a = VMIN; a <= VMAX; a++) begin
            for (int b = VMIN; b <= VMAX; b++) begin
               for (int k = 0; k < N; k++) begin
                  xs[k] = ((bg * 3 + k * 5) % 8) + VMIN;
                  ys[k] = ((bg * 7 + k * 3 + 1) % 8) + VMIN;
               end
               xs[lane] = a;
               ys[lane] = b;
               bg++;
               step(1'b1, xs, ys);
               // R4: idle slot with garbage data every few vectors
               if ((bg % 13) == 0) begin
                  for (int k = 0; k < N; k++) begin
                     xs[k] = VMAX;
                     ys[k] = VMIN;
                  end
                  step(1'b0, xs, ys);
               end
            end
         end
      end

      // R7: extreme operands on every lane
      for (int k = 0; k < N; k++) begin
         xs[k] = VMIN;
         ys[k] = VMIN;
      end
      step(1'b1, xs, ys);
      for (int k = 0; k < N; k++) ys[k] = VMAX;
      step(1'b1, xs, ys);
      for (int k = 0; k < N; k++) xs[k] = VMAX;
      step(1'b1, xs, ys);

      // drain with idle garbage
      for (int i = 0; i < N + 4; i++) begin
         for (int k = 0; k < N; k++) begin
            xs[k] = VMIN + k;
            ys[k] = VMAX - k;
         end
         step(1'b0, xs, ys);
      end

      // R5: reset again, valid must stay low in the first cycle after
      @(negedge clk);
      rst = 1'b1;
      for (int k = 0; k < N; k++) begin
         xs[k] = 1;
         ys[k] = 1;
      end
      drive(1'b1, xs, ys);
      @(negedge clk);
      rst = 1'b0;
      drive(1'b0, xs, ys);
      @(negedge clk);
      check("R5 valid after reset", int'(vld_a), 0);
      check("R5 valid after reset (out reg)", int'(vld_b), 0);
      check("R5 sum after reset (out reg)", int'(sum_b), 0);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule